// File: doc/BRIEF.md
# Gated Dual-Channel Pulse Counter

This block measures two pulse trains over a common time window so that a host can form a reciprocal frequency ratio. One input carries pulses from a sensor whose frequency tracks the quantity being measured. A second input carries reference pulses. A third input, the gate, is a slow strobe obtained by dividing a clock, with a nominal period of 100 ms. Every interval between two consecutive gate pulses forms one measurement window. During a window the block counts rising edges on the sensor and reference inputs.

When a gate pulse closes a window, both counts are copied into output registers together with a per-channel overflow flag. The running counters then restart from zero, and an interrupt flag tells the host that a new pair of values is ready. The host reads the pair and pulses an acknowledge input, which lowers the interrupt. If a second window closes before the host has acknowledged the first, a sticky overrun bit records that a result pair was lost. A counter that reaches its largest value stops there and reports overflow as an error. It never wraps back to a small, plausible-looking value.

Top module: `gated_pulse_counter`

## Requirements
- R1: Each of the three inputs passes through a two-flop synchronizer. A pulse adds exactly one to its channel's count on its rising edge, however many cycles it stays high.
- R2: After reset the first gate rising edge only opens a window. Pulses before it and pulses coinciding with it are not counted, and no result or interrupt appears.
- R3: At every later gate rising edge, the sensor and reference counts of the window just ended appear on `sens_count_o` and `ref_count_o`. The running counters restart at zero for the next window.
- R4: A sensor or reference rising edge that reaches the counter in the same cycle as a closing gate edge is included in the window being closed. It is not counted in the new window.
- R5: `irq_o` goes to 1 when a window closes and stays at 1 until a cycle in which `ack_i` is 1 and no window closes. `irq_o` is 0 in the cycle after that.
- R6: If `ack_i` is 1 in the same cycle as a window close, `irq_o` stays at 1 for the new result and `overrun_o` is not set.
- R7: If a window closes while `irq_o` is still 1 and `ack_i` is 0, `overrun_o` becomes 1 and stays at 1 until reset.
- R8: Each count saturates at 2^CNT_W-1 (CNT_W defaults to 24). The channel's overflow flag (`sens_ovf_o` or `ref_ovf_o`) is latched as 1 only if an edge arrived while that channel's count was already at the maximum. Exactly 2^CNT_W-1 edges give the maximum count with a flag of 0. The flag is recomputed for every window.
- R9: The latched counts and flags do not change between window closes, even while pulses are being counted.
- R10: Reset clears both counts, both overflow flags, `irq_o` and `overrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sensor_in | input | 1 | Sensor pulse train, asynchronous |
| ref_in | input | 1 | Reference pulse train, asynchronous |
| gate_in | input | 1 | Window strobe, asynchronous |
| ack_i | input | 1 | Host acknowledge of the ready result, one cycle |
| sens_count_o | output | CNT_W | Latched sensor count of the last window |
| ref_count_o | output | CNT_W | Latched reference count of the last window |
| sens_ovf_o | output | 1 | Sensor counter saturated during the last window |
| ref_ovf_o | output | 1 | Reference counter saturated during the last window |
| irq_o | output | 1 | Fresh result pending |
| overrun_o | output | 1 | A result closed while the previous one was unacknowledged |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a channel edge and the closing gate edge. The bench raises a sensor pulse and the gate in the same cycle, so both pass through equal synchronizer delays and meet at the counter. It then expects the edge in the closing count and a zero in the following window. The second pair is the acknowledge and a window close. The bench places `ack_i` exactly in the cycle where the synchronized gate edge latches the result, and expects `irq_o` to remain high with `overrun_o` still clear.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_t;

  localparam int unsigned CH_SENS = 0;
  localparam int unsigned CH_REF  = 1;
  localparam int unsigned N_CH    = 2;
  localparam int unsigned N_IN    = 3;

endpackage

// File: rtl/gpc_edge_sync.sv
module gpc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  assert_one_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/gpc_win_counter.sv
module gpc_win_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] final_cnt_o,
  output logic             final_ovf_o
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  function automatic logic [CNT_W-1:0] sat_step(input logic [CNT_W-1:0] v, input logic inc);
    return (inc && (v != MAXV)) ? v + ONE : v;
  endfunction

  function automatic logic hits_ceiling(input logic [CNT_W-1:0] v, input logic inc);
    return inc && (v == MAXV);
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i || !run_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= sat_step(cnt_q, inc_i);
      ovf_q <= ovf_q | hits_ceiling(cnt_q, inc_i);
    end
  end

  assign final_cnt_o = sat_step(cnt_q, inc_i);
  assign final_ovf_o = ovf_q | hits_ceiling(cnt_q, inc_i);

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && cnt_q == MAXV) |=> (cnt_q == MAXV));

  assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !clr_i && !inc_i) |=> $stable(cnt_q));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0 && !ovf_q));

endmodule

// File: rtl/gpc_result_bank.sv
module gpc_result_bank #(
  parameter int unsigned CNT_W = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            close_evt,
  input  logic                            ack_i,
  input  logic [gpc_pkg::N_CH-1:0][CNT_W-1:0] cnt_in,
  input  logic [gpc_pkg::N_CH-1:0]        ovf_in,
  output logic [gpc_pkg::N_CH-1:0][CNT_W-1:0] cnt_q,
  output logic [gpc_pkg::N_CH-1:0]        ovf_q,
  output logic                            irq_o,
  output logic                            overrun_o
);

  logic lost_evt;
  assign lost_evt = close_evt & irq_o & ~ack_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      ovf_q     <= '0;
      irq_o     <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (close_evt) begin
        cnt_q <= cnt_in;
        ovf_q <= ovf_in;
      end
      if (close_evt)  irq_o <= 1'b1;
      else if (ack_i) irq_o <= 1'b0;
      if (lost_evt) overrun_o <= 1'b1;
    end
  end

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(close_evt));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !close_evt) |=> !irq_o);

  assert_ack_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && close_evt && !overrun_o) |=> (irq_o && !overrun_o));

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |=> overrun_o);

  assert_hold_results_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !close_evt |=> ($stable(cnt_q) && $stable(ovf_q)));

endmodule

// File: rtl/gated_pulse_counter.sv
module gated_pulse_counter #(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sensor_in,
  input  logic             ref_in,
  input  logic             gate_in,
  input  logic             ack_i,
  output logic [CNT_W-1:0] sens_count_o,
  output logic [CNT_W-1:0] ref_count_o,
  output logic             sens_ovf_o,
  output logic             ref_ovf_o,
  output logic             irq_o,
  output logic             overrun_o
);
  import gpc_pkg::*;

  localparam int unsigned GATE_IDX = N_IN - 1;

  logic [N_IN-1:0] raw_in;
  logic [N_IN-1:0] rise;
  assign raw_in = {gate_in, ref_in, sensor_in};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_sync
    gpc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_in[gi]),
      .rise_o(rise[gi])
    );
  end

  win_state_t st_q;
  logic       open_evt;
  logic       close_evt;
  logic       win_run;

  assign win_run   = (st_q == WIN_OPEN);
  assign open_evt  = rise[GATE_IDX] & ~win_run;
  assign close_evt = rise[GATE_IDX] & win_run;

  always_ff @(posedge clk) begin
    if (!rst_n)        st_q <= WIN_IDLE;
    else if (open_evt) st_q <= WIN_OPEN;
  end

  logic [N_CH-1:0][CNT_W-1:0] win_cnt;
  logic [N_CH-1:0]            win_ovf;
  logic [N_CH-1:0][CNT_W-1:0] held_cnt;
  logic [N_CH-1:0]            held_ovf;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    gpc_win_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (win_run),
      .inc_i      (rise[ch] & win_run),
      .clr_i      (close_evt),
      .final_cnt_o(win_cnt[ch]),
      .final_ovf_o(win_ovf[ch])
    );
  end

  gpc_result_bank #(.CNT_W(CNT_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .close_evt(close_evt),
    .ack_i    (ack_i),
    .cnt_in   (win_cnt),
    .ovf_in   (win_ovf),
    .cnt_q    (held_cnt),
    .ovf_q    (held_ovf),
    .irq_o    (irq_o),
    .overrun_o(overrun_o)
  );

  assign sens_count_o = held_cnt[CH_SENS];
  assign ref_count_o  = held_cnt[CH_REF];
  assign sens_ovf_o   = held_ovf[CH_SENS];
  assign ref_ovf_o    = held_ovf[CH_REF];

  assert_idle_no_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == WIN_IDLE) |-> (!irq_o && sens_count_o == '0 && ref_count_o == '0));

  assert_open_once_R2: assert property (@(posedge clk) disable iff (!rst_n)
    win_run |=> win_run);

endmodule

// File: tb/gated_pulse_counter_test.sv
`timescale 1ns/1ps
module gated_pulse_counter_test;

  localparam int unsigned SMALL_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sensor_in = 1'b0, ref_in = 1'b0, gate_in = 1'b0, ack_i = 1'b0;

  logic [23:0] sens_count_o, ref_count_o;
  logic        sens_ovf_o, ref_ovf_o, irq_o, overrun_o;
  logic [SMALL_W-1:0] s_sens, s_ref;
  logic        s_sovf, s_rovf, s_irq, s_ovr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gated_pulse_counter uut (
    .clk(clk), .rst_n(rst_n), .sensor_in(sensor_in), .ref_in(ref_in),
    .gate_in(gate_in), .ack_i(ack_i),
    .sens_count_o(sens_count_o), .ref_count_o(ref_count_o),
    .sens_ovf_o(sens_ovf_o), .ref_ovf_o(ref_ovf_o),
    .irq_o(irq_o), .overrun_o(overrun_o)
  );

  gated_pulse_counter #(.CNT_W(SMALL_W)) small_uut (
    .clk(clk), .rst_n(rst_n), .sensor_in(sensor_in), .ref_in(ref_in),
    .gate_in(gate_in), .ack_i(ack_i),
    .sens_count_o(s_sens), .ref_count_o(s_ref),
    .sens_ovf_o(s_sovf), .ref_ovf_o(s_rovf),
    .irq_o(s_irq), .overrun_o(s_ovr)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sensor_in = 0; ref_in = 0; gate_in = 0; ack_i = 0;
    idle(4);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic pulses(input int ns, input int nr);
    int n;
    n = (ns > nr) ? ns : nr;
    for (int i = 0; i < n; i++) begin
      sensor_in = (i < ns);
      ref_in    = (i < nr);
      idle(2);
      sensor_in = 0; ref_in = 0;
      idle(2);
    end
  endtask

  task automatic gate_pulse();
    gate_in = 1'b1;
    idle(2);
    gate_in = 1'b0;
    idle(6);
  endtask

  task automatic ack_pulse();
    ack_i = 1'b1;
    idle(1);
    ack_i = 1'b0;
    idle(1);
    check("R5 irq cleared by ack", irq_o, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R10 sens count", sens_count_o, 0);
    check("R10 ref count", ref_count_o, 0);
    check("R10 ovf flags", {sens_ovf_o, ref_ovf_o}, 0);
    check("R10 irq", irq_o, 0);
    check("R10 overrun", overrun_o, 0);
  endtask

  task automatic t_first_gate_opens();
    do_reset();
    pulses(3, 2);
    gate_pulse();
    check("R2 no irq on opening gate", irq_o, 0);
    check("R2 sens count still zero", sens_count_o, 0);
    pulses(4, 2);
    gate_pulse();
    check("R3 sens count first window", sens_count_o, 4);
    check("R3 ref count first window", ref_count_o, 2);
    check("R5 irq raised", irq_o, 1);
    ack_pulse();
  endtask

  task automatic t_windows();
    pulses(7, 11);
    gate_pulse();
    check("R3 sens window 2", sens_count_o, 7);
    check("R3 ref window 2", ref_count_o, 11);
    check("R5 irq held before ack", irq_o, 1);
    idle(5);
    check("R5 irq still held", irq_o, 1);
    ack_pulse();
    gate_pulse();
    check("R3 empty window sens", sens_count_o, 0);
    check("R3 empty window ref", ref_count_o, 0);
    ack_pulse();
  endtask

  task automatic t_long_pulse();
    sensor_in = 1'b1;
    idle(12);
    sensor_in = 1'b0;
    idle(2);
    pulses(0, 1);
    gate_pulse();
    check("R1 long pulse counts once", sens_count_o, 1);
    check("R1 ref single", ref_count_o, 1);
    ack_pulse();
  endtask

  task automatic t_hold_between();
    pulses(3, 5);
    gate_pulse();
    ack_pulse();
    pulses(6, 2);
    check("R9 sens held while counting", sens_count_o, 3);
    check("R9 ref held while counting", ref_count_o, 5);
    check("R9 no irq mid-window", irq_o, 0);
    gate_pulse();
    check("R3 next window sens", sens_count_o, 6);
    ack_pulse();
  endtask

  task automatic t_coincident_edge();
    pulses(2, 0);
    sensor_in = 1'b1; gate_in = 1'b1;
    idle(2);
    sensor_in = 1'b0; gate_in = 1'b0;
    idle(6);
    check("R4 coincident edge in closing window", sens_count_o, 3);
    ack_pulse();
    gate_pulse();
    check("R4 new window starts at zero", sens_count_o, 0);
    ack_pulse();
  endtask

  task automatic t_ack_with_close();
    pulses(1, 1);
    gate_pulse();
    check("R5 irq pending", irq_o, 1);
    pulses(2, 3);
    gate_in = 1'b1;
    idle(2);
    ack_i = 1'b1;
    idle(1);
    ack_i = 1'b0; gate_in = 1'b0;
    idle(3);
    check("R6 irq kept by same-cycle close", irq_o, 1);
    check("R6 no overrun", overrun_o, 0);
    check("R6 new sens count", sens_count_o, 2);
    ack_pulse();
  endtask

  task automatic t_overrun();
    pulses(1, 0);
    gate_pulse();
    pulses(2, 0);
    gate_pulse();
    check("R7 overrun set", overrun_o, 1);
    check("R7 latest value kept", sens_count_o, 2);
    ack_pulse();
    idle(4);
    check("R7 overrun sticky", overrun_o, 1);
  endtask

  task automatic t_saturation();
    do_reset();
    gate_pulse();
    pulses(15, 17);
    gate_pulse();
    check("R8 exact max no flag count", s_sens, 15);
    check("R8 exact max no flag", s_sovf, 0);
    check("R8 saturated count", s_ref, 15);
    check("R8 overflow flag", s_rovf, 1);
    check("R8 wide counter no wrap", ref_count_o, 17);
    ack_pulse();
    pulses(2, 2);
    gate_pulse();
    check("R8 flag cleared next window", s_rovf, 0);
    check("R8 count after overflow", s_ref, 2);
    ack_pulse();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_first_gate_opens();
    t_windows();
    t_long_pulse();
    t_hold_between();
    t_coincident_edge();
    t_ack_with_close();
    t_overrun();
    t_saturation();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule